// File: doc/BRIEF.md
# Glitch-Free Clock Stop and Power-Down Gate

This block sits between a chip's clock sources and its clock output pins. It receives a CPU-domain clock, a PCI-domain clock and a reference clock. It drives a group of gated CPU copies, a group of gated PCI copies, one PCI copy that always runs, and a group of gated reference copies.

Two active-low stop inputs control the gated groups. One parks the gated PCI copies and the other parks the gated CPU copies. An asynchronous active-low power-down input stops every gated output. While power-down is asserted it overrides both stop inputs. Each output group is gated by an AND of its clock with an enable register that is loaded on the clock's falling edge. Because of this, a stop or a restart never produces a shortened pulse, and a stopped output always rests low.

A small sequencer in the reference domain takes the synchronized power-down input. It has three named states:
- `PM_WAKE` counts a startup interval after reset or after power-down is released.
- `PM_RUN` lets the gated groups run.
- `PM_DOWN` holds them off.

The transitions are:
- `go_down`: any state moves to `PM_DOWN` while synchronized power-down is low.
- `wake_up`: `PM_DOWN` moves to `PM_WAKE` when power-down is released.
- `lock_done`: `PM_WAKE` moves to `PM_RUN` after `STARTUP_CYC` reference cycles.

Reset places the sequencer in `PM_WAKE`. The run permission is passed through a two-flop synchronizer into each clock domain before it reaches that domain's enable register.

Top module: `clk_stop_pd_ctrl`

## Requirements
- R1: While `pci_halt_n_i` is 0 (and power-down is inactive), every bit of `pci_clk_o` stops toggling and rests at 0. While `pci_halt_n_i` is 1 and the sequencer is in `PM_RUN`, every bit follows `pci_clk_i`.
- R2: Every high pulse on any gated output lasts exactly half of its source clock period. Every low pulse lasts at least half a period. This holds across stops, restarts and power-down.
- R3: While `cpu_halt_n_i` is 0 (and power-down is inactive), every bit of `cpu_clk_o` stops toggling at 0. The PCI and reference outputs keep running.
- R4: The input `pwrdn_n_i` is passed through a two-flop synchronizer on `ref_clk_i`. While it is 0, `cpu_clk_o`, `pci_clk_o` and `ref_clk_o` all stop at 0.
- R5: While power-down is asserted, the values of `cpu_halt_n_i` and `pci_halt_n_i` have no effect on any output.
- R6: After power-down is released, the gated outputs stay at 0 until the sequencer has spent `STARTUP_CYC` reference cycles in `PM_WAKE`. After that they resume.
- R7: `pci_free_o` follows `pci_clk_i` at all times, independent of all three control inputs.
- R8: A stopped gated output always rests at the low level, never high.
- R9: After reset, all gated outputs are 0 until the startup interval of R6 has passed, while `pci_free_o` already toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n_i | input | 1 | Asynchronous active-low reset |
| cpu_clk_i | input | 1 | CPU-domain source clock |
| pci_clk_i | input | 1 | PCI-domain source clock |
| ref_clk_i | input | 1 | Reference source clock, also clocks the sequencer |
| cpu_halt_n_i | input | 1 | Active-low CPU stop, synchronous to `cpu_clk_i` |
| pci_halt_n_i | input | 1 | Active-low PCI stop, synchronous to `pci_free_o` |
| pwrdn_n_i | input | 1 | Asynchronous active-low power-down |
| cpu_clk_o | output | N_CPU | Gated CPU clock copies |
| pci_clk_o | output | N_PCI | Gated PCI clock copies |
| pci_free_o | output | 1 | Free-running PCI clock copy |
| ref_clk_o | output | N_REF | Gated reference clock copies |

## Verification
The assertions in the gate cells assume two things about the stop inputs. The CPU stop input is stable around falling edges of its own clock, and the PCI stop input is stable around falling edges of its own clock. The assertions in the sequencer assume that power-down reaches them only through the synchronizer. To stay within these assumptions, the bench changes both stop inputs one time unit after a rising edge of the PCI clock, which is also a rising edge of the CPU clock. Power-down is driven without regard to any clock, because the block synchronizes it. Pulse-width monitors on every output bit check each high and low phase against the source half period.

// File: rtl/clkpm_pkg.sv
package clkpm_pkg;
    typedef enum logic [1:0] {
        PM_WAKE = 2'd0,
        PM_RUN  = 2'd1,
        PM_DOWN = 2'd2
    } pm_state_e;

    localparam int SYNC_DEPTH = 2;
endpackage

// File: rtl/clkpm_sync.sv
module clkpm_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/clkpm_seq.sv
module clkpm_seq
    import clkpm_pkg::*;
#(
    parameter int STARTUP_CYC = 32
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic pwrdn_n_i,
    output logic run_ok_o
);
    localparam int CNT_W = $clog2(STARTUP_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STARTUP_CYC - 1);

    pm_state_e   state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic        pd_ok;   // 1 = power-down not requested (synchronized)

    clkpm_sync #(.STAGES(SYNC_DEPTH), .RST_VAL(1'b0)) u_pd_sync (
        .clk(ref_clk), .rst_n(rst_n), .d_i(pwrdn_n_i), .q_o(pd_ok)
    );

    // state register
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) state_q <= PM_WAKE;
        else        state_q <= state_d;
    end

    // transitions: go_down, wake_up, lock_done
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PM_WAKE: if (!pd_ok)                 state_d = PM_DOWN;
                     else if (cnt_q == CNT_LAST) state_d = PM_RUN;
            PM_RUN:  if (!pd_ok)                 state_d = PM_DOWN;
            PM_DOWN: if (pd_ok)                  state_d = PM_WAKE;
            default:                             state_d = PM_DOWN;
        endcase
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (state_q != PM_WAKE) cnt_q <= '0;
        else if (cnt_q != CNT_LAST)  cnt_q <= cnt_q + 1'b1;
    end

    // outputs
    always_comb begin
        run_ok_o = 1'b0;
        unique case (state_q)
            PM_RUN:  run_ok_o = 1'b1;
            PM_WAKE,
            PM_DOWN: run_ok_o = 1'b0;
            default: run_ok_o = 1'b0;
        endcase
    end

    p_pd_enter_r4: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !pd_ok |=> state_q == PM_DOWN);
    p_down_no_run_r5: assert property (@(posedge ref_clk) disable iff (!rst_n)
        state_q == PM_DOWN |-> !run_ok_o);
    p_pd_exit_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (state_q == PM_DOWN && pd_ok) |=> state_q == PM_WAKE);
    p_wake_hold_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (state_q == PM_WAKE && pd_ok && cnt_q != CNT_LAST) |=> state_q == PM_WAKE);
endmodule

// File: rtl/clkpm_gate.sv
module clkpm_gate
    import clkpm_pkg::*;
#(
    parameter int NOUT = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            far_en_i,   // from another domain, synchronized here
    input  logic            near_en_i,  // already synchronous to clk
    output logic [NOUT-1:0] clk_o
);
    logic far_s;
    logic en_q;

    clkpm_sync #(.STAGES(SYNC_DEPTH), .RST_VAL(1'b0)) u_en_sync (
        .clk(clk), .rst_n(rst_n), .d_i(far_en_i), .q_o(far_s)
    );

    // loaded only while clk is low, so the AND below never cuts a phase
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= near_en_i & far_s;
    end

    for (genvar g = 0; g < NOUT; g++) begin : g_copy
        assign clk_o[g] = clk & en_q;
    end

    p_near_off_r1: assert property (@(negedge clk) disable iff (!rst_n)
        !near_en_i |=> !en_q);
    p_far_off_r4: assert property (@(negedge clk) disable iff (!rst_n)
        !far_s |=> !en_q);
endmodule

// File: rtl/clk_stop_pd_ctrl.sv
module clk_stop_pd_ctrl #(
    parameter int N_CPU       = 2,
    parameter int N_PCI       = 5,
    parameter int N_REF       = 2,
    parameter int STARTUP_CYC = 32
) (
    input  logic             rst_n_i,
    input  logic             cpu_clk_i,
    input  logic             pci_clk_i,
    input  logic             ref_clk_i,
    input  logic             cpu_halt_n_i,
    input  logic             pci_halt_n_i,
    input  logic             pwrdn_n_i,
    output logic [N_CPU-1:0] cpu_clk_o,
    output logic [N_PCI-1:0] pci_clk_o,
    output logic             pci_free_o,
    output logic [N_REF-1:0] ref_clk_o
);
    logic run_ok;

    clkpm_seq #(.STARTUP_CYC(STARTUP_CYC)) u_seq (
        .ref_clk(ref_clk_i), .rst_n(rst_n_i), .pwrdn_n_i(pwrdn_n_i), .run_ok_o(run_ok)
    );

    clkpm_gate #(.NOUT(N_CPU)) u_cpu_gate (
        .clk(cpu_clk_i), .rst_n(rst_n_i), .far_en_i(run_ok),
        .near_en_i(cpu_halt_n_i), .clk_o(cpu_clk_o)
    );

    clkpm_gate #(.NOUT(N_PCI)) u_pci_gate (
        .clk(pci_clk_i), .rst_n(rst_n_i), .far_en_i(run_ok),
        .near_en_i(pci_halt_n_i), .clk_o(pci_clk_o)
    );

    clkpm_gate #(.NOUT(N_REF)) u_ref_gate (
        .clk(ref_clk_i), .rst_n(rst_n_i), .far_en_i(run_ok),
        .near_en_i(1'b1), .clk_o(ref_clk_o)
    );

    assign pci_free_o = pci_clk_i;
endmodule

// File: tb/clk_stop_pd_ctrl_tb_top.sv
`timescale 1ns/1ps
module clkpm_pulse_mon #(
    parameter real   HALF = 5.0,
    parameter string TAG  = "x"
) (
    input  logic sig,
    output int   chk_o,
    output int   bad_o
);
    realtime t_rise, t_fall;
    bit seen_r, seen_f;
    int hi_chk, hi_bad, lo_chk, lo_bad;

    initial begin
        seen_r = 0; seen_f = 0; hi_chk = 0; hi_bad = 0; lo_chk = 0; lo_bad = 0;
    end

    always @(posedge sig) begin
        if (seen_f) begin
            lo_chk++;
            if ($realtime - t_fall < HALF - 0.001) begin
                lo_bad++;
                $display("FAIL R2 %s low pulse: actual=%0.3f expected>=%0.3f", TAG, $realtime - t_fall, HALF);
            end
        end
        t_rise = $realtime; seen_r = 1;
    end

    always @(negedge sig) begin
        if (seen_r) begin
            hi_chk++;
            if (($realtime - t_rise > HALF + 0.001) || ($realtime - t_rise < HALF - 0.001)) begin
                hi_bad++;
                $display("FAIL R2 %s high pulse: actual=%0.3f expected=%0.3f", TAG, $realtime - t_rise, HALF);
            end
        end
        t_fall = $realtime; seen_f = 1;
    end

    assign chk_o = hi_chk + lo_chk;
    assign bad_o = hi_bad + lo_bad;
endmodule

module clk_stop_pd_ctrl_tb_top;
    localparam real CLK_PERIOD = 10.0;   // CPU clock
    localparam real REF_PERIOD = 14.0;
    localparam int  N_CPU = 2, N_PCI = 5, N_REF = 2, NMON = N_CPU + N_PCI + N_REF + 1;

    logic rst_n, cpu_clk, pci_clk, ref_clk, cpu_halt_n, pci_halt_n, pwrdn_n;
    logic [N_CPU-1:0] cpu_clk_o;
    logic [N_PCI-1:0] pci_clk_o;
    logic             pci_free_o;
    logic [N_REF-1:0] ref_clk_o;

    int checks = 0, errors = 0;
    int mon_chk [NMON];
    int mon_bad [NMON];

    clk_stop_pd_ctrl #(.N_CPU(N_CPU), .N_PCI(N_PCI), .N_REF(N_REF), .STARTUP_CYC(32)) dut_i (
        .rst_n_i(rst_n), .cpu_clk_i(cpu_clk), .pci_clk_i(pci_clk), .ref_clk_i(ref_clk),
        .cpu_halt_n_i(cpu_halt_n), .pci_halt_n_i(pci_halt_n), .pwrdn_n_i(pwrdn_n),
        .cpu_clk_o(cpu_clk_o), .pci_clk_o(pci_clk_o), .pci_free_o(pci_free_o), .ref_clk_o(ref_clk_o)
    );

    for (genvar g = 0; g < N_CPU; g++) begin : g_mc
        clkpm_pulse_mon #(.HALF(CLK_PERIOD/2), .TAG("cpu")) u_m (.sig(cpu_clk_o[g]), .chk_o(mon_chk[g]), .bad_o(mon_bad[g]));
    end
    for (genvar g = 0; g < N_PCI; g++) begin : g_mp
        clkpm_pulse_mon #(.HALF(CLK_PERIOD), .TAG("pci")) u_m (.sig(pci_clk_o[g]), .chk_o(mon_chk[N_CPU+g]), .bad_o(mon_bad[N_CPU+g]));
    end
    for (genvar g = 0; g < N_REF; g++) begin : g_mr
        clkpm_pulse_mon #(.HALF(REF_PERIOD/2), .TAG("ref")) u_m (.sig(ref_clk_o[g]), .chk_o(mon_chk[N_CPU+N_PCI+g]), .bad_o(mon_bad[N_CPU+N_PCI+g]));
    end
    clkpm_pulse_mon #(.HALF(CLK_PERIOD), .TAG("free")) u_mf (.sig(pci_free_o), .chk_o(mon_chk[NMON-1]), .bad_o(mon_bad[NMON-1]));

    initial cpu_clk = 0;
    always #(CLK_PERIOD/2) cpu_clk = ~cpu_clk;
    initial pci_clk = 0;
    always @(posedge cpu_clk) pci_clk <= ~pci_clk;
    initial ref_clk = 0;
    always #(REF_PERIOD/2) ref_clk = ~ref_clk;

    // vector: {pci_halt_n, cpu_halt_n, pwrdn_n, exp_cpu_run, exp_pci_run, exp_ref_run}
    localparam logic [5:0] VEC [7] = '{
        6'b111_111,   // all run
        6'b011_101,   // PCI stopped (R1)
        6'b101_011,   // CPU stopped (R3)
        6'b001_001,   // both stopped, ref runs
        6'b110_000,   // power-down (R4)
        6'b000_000,   // stops toggled under power-down (R5)
        6'b111_111    // resume (R6)
    };

    logic [N_CPU-1:0] saw_cpu;
    logic [N_PCI-1:0] saw_pci;
    logic [N_REF-1:0] saw_ref;
    logic             saw_free;

    task automatic observe(input real win);
        saw_cpu = '0; saw_pci = '0; saw_ref = '0; saw_free = 0;
        for (int t = 0; t < int'(win); t++) begin
            #1;
            saw_cpu |= cpu_clk_o; saw_pci |= pci_clk_o; saw_ref |= ref_clk_o; saw_free |= pci_free_o;
        end
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_groups(input string tag, input bit ec, input bit ep, input bit er);
        check({tag, " R3 R8 cpu"}, 32'(saw_cpu), ec ? 32'((1 << N_CPU) - 1) : 32'd0);
        check({tag, " R1 R8 pci"}, 32'(saw_pci), ep ? 32'((1 << N_PCI) - 1) : 32'd0);
        check({tag, " R4 ref"},    32'(saw_ref), er ? 32'((1 << N_REF) - 1) : 32'd0);
        check({tag, " R7 free"},   32'(saw_free), 32'd1);
    endtask

    task automatic finish_run;
        for (int i = 0; i < NMON; i++) begin
            checks += mon_chk[i];
            errors += mon_bad[i];
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        rst_n = 0; cpu_halt_n = 1; pci_halt_n = 1; pwrdn_n = 1;
        #50;
        rst_n = 1;
        // R9: reset state, outputs quiet during startup, free clock runs
        observe(150.0);
        check_groups("R9 reset", 0, 0, 0);
        #1000;

        // table walk
        for (int v = 0; v < 7; v++) begin
            @(posedge pci_clk); #1;
            pci_halt_n = VEC[v][5]; cpu_halt_n = VEC[v][4]; pwrdn_n = VEC[v][3];
            #1000;
            observe(200.0);
            check_groups($sformatf("vec%0d", v), VEC[v][2], VEC[v][1], VEC[v][0]);
        end

        // R6: startup latency after power-down release
        pwrdn_n = 0;
        #400;
        pwrdn_n = 1;
        observe(150.0);
        check_groups("R6 early", 0, 0, 0);
        #1000;
        observe(200.0);
        check_groups("R6 late", 1, 1, 1);

        // R5: stop inputs changing mid power-down have no effect, then released state applies
        @(posedge pci_clk); #1;
        pwrdn_n = 0;
        #400;
        @(posedge pci_clk); #1;
        pci_halt_n = 0;
        observe(200.0);
        check_groups("R5 pd hold", 0, 0, 0);
        @(posedge pci_clk); #1;
        pci_halt_n = 1; cpu_halt_n = 0;
        observe(200.0);
        check_groups("R5 pd hold2", 0, 0, 0);
        pwrdn_n = 1;
        #1200;
        observe(200.0);
        check_groups("R3 after wake", 0, 1, 1);

        // short power-down glitch: R2 monitors watch the abrupt stop/start
        @(posedge pci_clk); #1;
        cpu_halt_n = 1;
        #3;
        pwrdn_n = 0;
        #37;
        pwrdn_n = 1;
        #1500;
        observe(200.0);
        check_groups("R2 recover", 1, 1, 1);

        finish_run();
    end
endmodule